// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A four-bit synchronous up-counter slice with active-low control inputs. It can be preset from a parallel data word. It has two count-enable inputs and a combinational terminal-count flag, so several slices can be joined into one wide counter. The wide counter advances in a single clock edge, with no lag between slices.

In a chain, every slice shares the clock, the clear, the load strobe and the parallel enable. Each slice's terminal-count output feeds the chain enable of the next, more significant slice. A build-time parameter selects how the clear acts. It is either asynchronous, acting as soon as it goes low, or synchronous, acting on the next rising clock edge.

Top module: `presettable_counter`

## Requirements
- R1: With clear and load both inactive (high) and both enables high, the count increments by one on each rising clock edge, wrapping from 15 to 0.
- R2: With `SYNC_CLR` = 0, a low `clr_n` forces `q` to 0 at once, without waiting for a clock edge and regardless of every other input.
- R3: With `SYNC_CLR` = 1, a low `clr_n` leaves `q` unchanged until the next rising edge, then sets it to 0, overriding both load and count.
- R4: With `clr_n` high and `ld_n` low, `din` is copied into `q` on the next rising edge, whatever the enables are.
- R5: With `clr_n` and `ld_n` high, `q` holds its value across an edge if either `en_par` or `en_chain` is low.
- R6: `tc_out` is high exactly when `en_chain` is high and `q` equals 15. `en_par` and `ld_n` have no effect on it.
- R7: Three slices chained through `tc_out` to `en_chain`, sharing all other controls, step together as one 12-bit binary counter. This includes carries across slice boundaries and the wrap from 4095 to 0.
- R8: After an asynchronous clear is released, `q` stays at 0 until the first edge at which counting is enabled, and then becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous depending on `SYNC_CLR` |
| ld_n | input | 1 | Active-low parallel load strobe |
| din | input | WIDTH | Parallel preset value |
| en_par | input | 1 | Count enable shared by all slices of a chain |
| en_chain | input | 1 | Count enable that also gates `tc_out`; fed from the previous slice |
| q | output | WIDTH | Counter state |
| tc_out | output | 1 | Terminal count: `en_chain` and all-ones state |

## Verification
The embedded properties check the following on every clock edge:
- the single-slice transitions: increment with wrap, load, hold, and the clear result for the selected variant;
- that a raised terminal count under an active count produces a zero state on the next edge.

Some behaviours span more than one edge or more than one slice, and only the bench scenarios show them:
- the clear taking effect between edges in the asynchronous variant, while the synchronous chain waits for the edge;
- the clear winning over a simultaneous load;
- ripple-free carry propagation through three chained slices;
- the restart from zero after clear release.

// File: rtl/pctr_pkg.sv
package pctr_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } pctr_op_e;
endpackage

// File: rtl/pctr_ctrl.sv
module pctr_ctrl
  import pctr_pkg::*;
(
  input  logic     clr_n,
  input  logic     ld_n,
  input  logic     en_par,
  input  logic     en_chain,
  output pctr_op_e op
);
  // Fixed precedence: clear, load, count, hold.
  always_comb begin
    if (!clr_n)                    op = OP_CLEAR;
    else if (!ld_n)                op = OP_LOAD;
    else if (en_par && en_chain)   op = OP_COUNT;
    else                           op = OP_HOLD;
  end
endmodule

// File: rtl/pctr_next.sv
module pctr_next
  import pctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  pctr_op_e         op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/pctr_state_reg.sv
module pctr_state_reg #(
  parameter int WIDTH    = 4,
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_r;

  generate
    if (SYNC_CLR) begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= nxt;
      end

      // R3
      sync_clear_chk: assert property (@(posedge clk)
        !clr_n |=> (q_r == '0));
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= nxt;
      end

      // R2
      async_clear_chk: assert property (@(posedge clk)
        !clr_n |-> (q_r == '0));
    end
  endgenerate

  assign q = q_r;
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import pctr_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter bit SYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_par,
  input  logic             en_chain,
  output logic [WIDTH-1:0] q,
  output logic             tc_out
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  pctr_op_e         op;
  logic [WIDTH-1:0] nxt;

  pctr_ctrl u_ctrl (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .en_par   (en_par),
    .en_chain (en_chain),
    .op       (op)
  );

  pctr_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  pctr_state_reg #(.WIDTH(WIDTH), .SYNC_CLR(SYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  // Combinational so that a chained slice sees the carry in the same cycle.
  assign tc_out = en_chain & (&q);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_par && en_chain) |=> (q == $past(q) + ONE));

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> (q == $past(din)));

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_par && en_chain)) |=> $stable(q));

  // R6
  tc_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (tc_out && en_par && ld_n) |=> (q == '0));
endmodule

// File: tb/presettable_counter_tb.sv
module presettable_counter_tb;
  logic       clk = 1'b0;
  logic       clr_n, ld_n, en_par, en_chain;
  logic [3:0] din;
  logic [3:0] q;
  logic       tc;
  logic [3:0] cq0, cq1, cq2;
  logic       ctc0, ctc1, ctc2;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [3:0]  m4;
  logic [11:0] m12;

  always #4 clk = ~clk;

  // Standalone slice, asynchronous clear.
  presettable_counter #(.WIDTH(4), .SYNC_CLR(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_par(en_par), .en_chain(en_chain), .q(q), .tc_out(tc));

  // Three-slice chain, synchronous clear.
  presettable_counter #(.WIDTH(4), .SYNC_CLR(1'b1)) u_c0 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_par(en_par), .en_chain(en_chain), .q(cq0), .tc_out(ctc0));
  presettable_counter #(.WIDTH(4), .SYNC_CLR(1'b1)) u_c1 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_par(en_par), .en_chain(ctc0), .q(cq1), .tc_out(ctc1));
  presettable_counter #(.WIDTH(4), .SYNC_CLR(1'b1)) u_c2 (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_par(en_par), .en_chain(ctc1), .q(cq2), .tc_out(ctc2));

  function automatic logic [3:0] step4(logic [3:0] cur, logic c, logic l,
                                       logic [3:0] d, logic p, logic t);
    if (!c)         return 4'd0;
    else if (!l)    return d;
    else if (p & t) return cur + 4'd1;
    else            return cur;
  endfunction

  function automatic logic [11:0] step12(logic [11:0] cur, logic c, logic l,
                                         logic [3:0] d, logic p, logic t);
    if (!c)         return 12'd0;
    else if (!l)    return {d, d, d};
    else if (p & t) return cur + 12'd1;
    else            return cur;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " slice q"}, 32'(q), 32'(m4));
    check("R6 slice tc", 32'(tc), 32'(en_chain && m4 == 4'hF));
    check("R7 chain value", 32'({cq2, cq1, cq0}), 32'(m12));
    check("R7 chain tc", 32'(ctc2), 32'(en_chain && m12 == 12'hFFF));
  endtask

  task automatic cycle(logic c, logic l, logic [3:0] d, logic p, logic t,
                       string tag);
    @(negedge clk);
    clr_n = c; ld_n = l; din = d; en_par = p; en_chain = t;
    @(posedge clk);
    m4  = step4(m4, c, l, d, p, t);
    m12 = step12(m12, c, l, d, p, t);
    #2;
    compare(tag);
  endtask

  function automatic string pick_tag(logic c, logic l, logic p, logic t);
    if (!c)         return "R3";
    else if (!l)    return "R4";
    else if (p & t) return "R1";
    else            return "R5";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    clr_n = 1'b0; ld_n = 1'b1; din = 4'h0; en_par = 1'b0; en_chain = 1'b0;
    m4 = '0; m12 = '0;

    // Reset state.
    cycle(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, "R2");
    cycle(1'b0, 1'b1, 4'h0, 1'b1, 1'b1, "R3");

    // R8: released but disabled, then first enabled edge.
    cycle(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, "R8 hold at 0");
    cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R8 resume");

    // R4: load with enables low.
    cycle(1'b1, 1'b0, 4'hE, 1'b0, 1'b0, "R4");
    // R7: carry across slice boundaries 0xEEE -> 0xEEF -> 0xEF0.
    cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R1");
    cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R7 carry");

    // R6: terminal count with en_par low, then load strobe, then en_chain low.
    cycle(1'b1, 1'b0, 4'hF, 1'b0, 1'b1, "R4");
    cycle(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, "R5");
    @(negedge clk);
    ld_n = 1'b0; din = 4'h3; en_par = 1'b1;
    #1;
    check("R6 tc ignores ld_n/en_par", 32'(tc), 32'd1);
    en_chain = 1'b0;
    #1;
    check("R6 tc gated by en_chain", 32'(tc), 32'd0);
    ld_n = 1'b1;
    @(posedge clk);
    m4  = step4(m4, 1'b1, 1'b1, 4'h3, 1'b1, 1'b0);
    m12 = step12(m12, 1'b1, 1'b1, 4'h3, 1'b1, 1'b0);
    #2;
    compare("R5");

    // R1 / R7: wrap 15 -> 0 and 4095 -> 0.
    cycle(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R1 wrap");

    // R2 / R3: clear mid-cycle together with a load request.
    cycle(1'b1, 1'b0, 4'h9, 1'b0, 1'b0, "R4");
    @(negedge clk);
    clr_n = 1'b0; ld_n = 1'b0; din = 4'h5; en_par = 1'b1; en_chain = 1'b1;
    #1;
    check("R2 immediate clear", 32'(q), 32'd0);
    check("R3 chain waits for edge", 32'({cq2, cq1, cq0}), 32'(m12));
    m4 = 4'd0;
    @(posedge clk);
    m4  = step4(m4, 1'b0, 1'b0, 4'h5, 1'b1, 1'b1);
    m12 = step12(m12, 1'b0, 1'b0, 4'h5, 1'b1, 1'b1);
    #2;
    compare("R3 clear beats load");

    // Constrained random traffic.
    for (int i = 0; i < 400; i++) begin
      logic c, l, p, t;
      logic [3:0] d;
      c = ($urandom_range(0, 99) >= 4);
      l = ($urandom_range(0, 99) >= 8);
      p = ($urandom_range(0, 99) >= 15);
      t = ($urandom_range(0, 99) >= 15);
      d = 4'($urandom_range(0, 15));
      cycle(c, l, d, p, t, pick_tag(c, l, p, t));
    end

    finish_run();
  end
endmodule